// File: doc/BRIEF.md
# Local Bus Memory and Peripheral Cycle Controller

This block turns single internal read and write requests into timed cycles on an external 16-bit local bus that serves three devices: a RAM, a ROM and one user-defined auxiliary peripheral. A requester presents an address, a two-bit region code, write data, byte enables and a direction, and holds the request until the block shows it is ready. The block then drives the address, an active-low chip select for the chosen device, an active-low output enable for reads, and two active-low byte write strobes for writes. The local bus clock output is the system clock passed straight through.

Every cycle has three parts. A strobe phase lasts one clock plus a programmable number of wait states (0 to 15). Once the wait states run out, the strobe phase goes on for as long as the external ready input stays low. A hold clock follows, in which address and chip select stay put with all strobes released. Write strobes fall on the falling clock edge inside the strobe phase, so address, data and chip select are settled half a clock before them. The strobes rise on the rising edge that ends the phase. Read data is captured on that same rising edge and returned with a one-clock response pulse.

Top module: `lbus_ctrl`

## Requirements
- R1: While reset is low and right after it is released, all three chip selects, both write strobes and the output enable are high, `reqReady` is high, `rspValid` is low, and `busAddr` and `rspRdata` are zero.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both high. From that edge `busAddr` equals the request address. The chip select for region code 0 (`ramCsN`), 1 (`romCsN`) or 2 (`auxCsN`) is low through the strobe and hold phases. At most one chip select is ever low.
- R3: Region code 3 runs a cycle with normal timing and response, but no chip select goes low.
- R4: In a write, strobe bit b (bit 0 covers data bits 7:0, bit 1 covers bits 15:8) goes low at the first falling edge after acceptance, but only if byte enable b is 1. A byte enable of 0 leaves its strobe high for the whole cycle. `busDataOe` is high and `busDataOut` holds the write data through the strobe and hold phases. Address and chip select do not change while a strobe is low.
- R5: With W wait states and ready high, a cycle accepted at edge k ends its strobe phase at rising edge k+1+W. All strobes and the output enable rise at that edge, and `rspValid` is high for exactly the following clock.
- R6: Once the wait states are used up, each rising edge that samples `busRdy` low adds one clock to the strobe phase. The phase ends on the first rising edge that samples `busRdy` high.
- R7: In a read, `busOeN` is low exactly during the strobe phase, the write strobes stay high and `busDataOe` stays low. `rspRdata` takes the `busDataIn` value sampled at the ending edge and keeps it until the next read completes.
- R8: The clock after the strobe phase is a hold clock, with address and chip select unchanged and `reqReady` high. A request accepted at the end of that clock starts the next cycle directly.
- R9: `busClk` equals `clk` at all times.
- R10: `reqValid` and the request fields are ignored while `reqReady` is low (strobe phase). The bus outputs keep the values of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRegion | input | 2 | 0 RAM, 1 ROM, 2 auxiliary, 3 no device |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Byte enables for writes |
| waitStates | input | 4 | Programmed wait-state count |
| reqReady | output | 1 | Request can be accepted at the next edge |
| rspValid | output | 1 | One-clock completion pulse |
| rspRdata | output | 16 | Last read data captured |
| busClk | output | 1 | Forwarded local bus clock |
| busAddr | output | 16 | Local bus address |
| busDataOut | output | 16 | Write data toward the bus |
| busDataOe | output | 1 | Drive enable for the data pins |
| busDataIn | input | 16 | Read data from the bus |
| busOeN | output | 1 | Active-low output enable |
| busWeN | output | 2 | Active-low byte write strobes |
| ramCsN | output | 1 | Active-low RAM chip select |
| romCsN | output | 1 | Active-low ROM chip select |
| auxCsN | output | 1 | Active-low auxiliary chip select |
| busRdy | input | 1 | External ready, extends the strobe phase |

## Verification
Address, chip select, output enable and data drive change at the accepting rising edge. The write strobes change half a clock later, at the falling edge. Completion and read data show up one clock after the edge where the wait count has reached zero and ready is high. A behavioural model in the bench steps once per rising edge, and every output is compared with it three quarters of a clock after each rising edge. By then both the rising-edge registers and the falling-edge strobe registers have settled. Inputs change a short time after the rising edge, so the model and the design always sample the same values.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_HOLD   = 2'd2
  } lbusState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request fields at this edge
    logic strobe;  // strobe phase active
    logic hold;    // hold clock active
    logic finish;  // strobe phase ends at this edge
  } lbusCtl_t;

  localparam int unsigned NUM_CS = 3;

endpackage

// File: rtl/lbus_ctrl_fsm.sv
module lbus_ctrl_fsm
  import lbus_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              busRdy,
  input  logic [WAIT_W-1:0] waitStates,
  output logic              reqReady,
  output lbusCtl_t          ctl
);

  lbusState_t        state;
  lbusState_t        stateNext;
  logic [WAIT_W-1:0] waitCnt;
  logic              cntZero;
  logic              finish;
  logic              accept;

  assign cntZero  = (waitCnt == '0);
  assign reqReady = (state != ST_STROBE);
  assign accept   = reqReady && reqValid;
  assign finish   = (state == ST_STROBE) && cntZero && busRdy;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_HOLD: stateNext = accept ? ST_STROBE : ST_IDLE;
      ST_STROBE:        stateNext = finish ? ST_HOLD : ST_STROBE;
      default:          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        waitCnt <= waitStates;
      end else if (state == ST_STROBE && !cntZero) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.load   = accept;
    ctl.strobe = (state == ST_STROBE);
    ctl.hold   = (state == ST_HOLD);
    ctl.finish = finish;
  end

  // R6: after the wait states are used up, low ready keeps the strobe phase going
  a_r6_wait_on_ready : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && cntZero && !busRdy) |=> (state == ST_STROBE));

  // R5: each wait state adds exactly one clock
  a_r5_count_down : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && !cntZero) |=> (state == ST_STROBE && waitCnt == $past(waitCnt) - 1'b1));

  // R8: the hold phase lasts exactly one clock
  a_r8_single_hold : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> (state != ST_HOLD));

  // R5: the strobe phase is always followed by hold
  a_r5_strobe_to_hold : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && stateNext != ST_STROBE) |=> (state == ST_HOLD));

endmodule

// File: rtl/lbus_ctrl_dp.sv
module lbus_ctrl_dp
  import lbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lbusCtl_t              ctl,
  input  logic                  reqWrite,
  input  logic [1:0]            reqRegion,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqByteEn,
  input  logic [DATA_W-1:0]     busDataIn,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [DATA_W-1:0]     busDataOut,
  output logic                  busDataOe,
  output logic                  busOeN,
  output logic [DATA_W/8-1:0]   busWeN,
  output logic [NUM_CS-1:0]     csN,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspRdata
);

  localparam int unsigned NBYTE = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [NBYTE-1:0]  beQ;
  logic [1:0]        regionQ;
  logic              writeQ;
  logic              rspQ;
  logic              cycActive;
  logic [NBYTE-1:0]  weLow;
  logic              weAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      beQ     <= '0;
      regionQ <= '0;
      writeQ  <= 1'b0;
      rdataQ  <= '0;
      rspQ    <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ   <= reqAddr;
        dataQ   <= reqWdata;
        beQ     <= reqByteEn;
        regionQ <= reqRegion;
        writeQ  <= reqWrite;
      end
      if (ctl.finish && !writeQ) begin
        rdataQ <= busDataIn;
      end
      rspQ <= ctl.finish;
    end
  end

  assign cycActive  = ctl.strobe || ctl.hold;
  assign busAddr    = addrQ;
  assign busDataOut = dataQ;
  assign busDataOe  = cycActive && writeQ;
  assign busOeN     = !(ctl.strobe && !writeQ);
  assign rspValid   = rspQ;
  assign rspRdata   = rdataQ;

  // byte strobes: armed on the falling edge, dropped with the strobe phase
  for (genvar b = 0; b < NBYTE; b++) begin : g_strobe
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) begin
        weLow[b] <= 1'b0;
      end else begin
        weLow[b] <= ctl.strobe && writeQ && beQ[b];
      end
    end
    assign busWeN[b] = !(weLow[b] && ctl.strobe);
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = !(cycActive && (regionQ == 2'(i)));
  end

  assign weAny = !(&busWeN);

  // R2: never two devices selected
  a_r2_cs_onehot0 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R4: address and select stay put while a strobe is low
  a_r4_addr_stable : assert property (@(posedge clk) disable iff (!rstN)
    (weAny && $past(weAny)) |-> ($stable(busAddr) && $stable(csN)));

  // R7: reads never strobe
  a_r7_read_no_we : assert property (@(posedge clk) disable iff (!rstN)
    !busOeN |-> ((&busWeN) && !busDataOe));

  // R5: strobes are released while the response is shown
  a_r5_released_on_rsp : assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((&busWeN) && busOeN));

endmodule

// File: rtl/lbus_ctrl.sv
module lbus_ctrl
  import lbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [1:0]          reqRegion,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [WAIT_W-1:0]   waitStates,
  output logic                reqReady,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                busClk,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busDataOut,
  output logic                busDataOe,
  input  logic [DATA_W-1:0]   busDataIn,
  output logic                busOeN,
  output logic [DATA_W/8-1:0] busWeN,
  output logic                ramCsN,
  output logic                romCsN,
  output logic                auxCsN,
  input  logic                busRdy
);

  lbusCtl_t          ctl;
  logic [NUM_CS-1:0] csN;

  assign busClk = clk;  // R9

  lbus_ctrl_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .busRdy     (busRdy),
    .waitStates (waitStates),
    .reqReady   (reqReady),
    .ctl        (ctl)
  );

  lbus_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqWrite   (reqWrite),
    .reqRegion  (reqRegion),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqByteEn  (reqByteEn),
    .busDataIn  (busDataIn),
    .busAddr    (busAddr),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .busOeN     (busOeN),
    .busWeN     (busWeN),
    .csN        (csN),
    .rspValid   (rspValid),
    .rspRdata   (rspRdata)
  );

  assign ramCsN = csN[0];
  assign romCsN = csN[1];
  assign auxCsN = csN[2];

endmodule

// File: tb/lbus_ctrl_tb.sv
module lbus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqRegion = '0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic [3:0]  waitStates = '0;
  logic [15:0] busDataIn = '0;
  logic        busRdy = 1'b1;
  logic        reqReady, rspValid, busClk, busDataOe, busOeN;
  logic        ramCsN, romCsN, auxCsN;
  logic [15:0] rspRdata, busAddr, busDataOut;
  logic [1:0]  busWeN;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  lbus_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRegion(reqRegion), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqByteEn(reqByteEn), .waitStates(waitStates), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .busClk(busClk),
    .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .busOeN(busOeN), .busWeN(busWeN),
    .ramCsN(ramCsN), .romCsN(romCsN), .auxCsN(auxCsN), .busRdy(busRdy)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 strobe, 2 hold
  int          mPhase = 0;
  int          mCnt = 0;
  int          mRegion = 0;
  bit          mWrite = 0;
  bit [1:0]    mBe = 0;
  bit [15:0]   mAddr = 0;
  bit [15:0]   mData = 0;
  bit [15:0]   mRdata = 0;
  bit          mRsp = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mRsp = 0; mRdata = 0; mAddr = 0; mCnt = 0;
    end else begin
      mRsp = 0;
      if (mPhase == 1) begin
        if (mCnt != 0) mCnt = mCnt - 1;
        else if (busRdy) begin
          mPhase = 2; mRsp = 1;
          if (!mWrite) mRdata = busDataIn;
        end
      end else if (reqValid) begin
        mPhase = 1; mCnt = int'(waitStates); mAddr = reqAddr; mData = reqWdata;
        mWrite = reqWrite; mBe = reqByteEn; mRegion = int'(reqRegion);
      end else begin
        mPhase = 0;
      end
    end
  end

  // compare three quarters into each clock, after the falling-edge strobes
  always @(posedge clk) begin
    #15;
    if (rstN) begin
      bit act;
      act = (mPhase != 0);
      chk("R2", "ramCsN", ramCsN, !(act && mRegion == 0));
      chk("R2", "romCsN", romCsN, !(act && mRegion == 1));
      chk("R2 R3", "auxCsN", auxCsN, !(act && mRegion == 2));
      chk("R2 R10", "busAddr", busAddr, mAddr);
      for (int b = 0; b < 2; b++)
        chk("R4", "busWeN", busWeN[b], !(mPhase == 1 && mWrite && mBe[b]));
      chk("R7", "busOeN", busOeN, !(mPhase == 1 && !mWrite));
      chk("R4 R7", "busDataOe", busDataOe, act && mWrite);
      if (act && mWrite) chk("R4", "busDataOut", busDataOut, mData);
      chk("R5 R6", "rspValid", rspValid, mRsp);
      chk("R7", "rspRdata", rspRdata, mRdata);
      chk("R8 R10", "reqReady", reqReady, mPhase != 1);
      chk("R9", "busClk", busClk, clk);
    end
  end

  task automatic issue(input bit w, input bit [1:0] rg, input bit [15:0] a,
                       input bit [15:0] d, input bit [1:0] be, input bit [3:0] ws);
    bit ok;
    reqValid = 1; reqWrite = w; reqRegion = rg; reqAddr = a;
    reqWdata = d; reqByteEn = be; waitStates = ws;
    do begin
      ok = (mPhase != 1);
      @(posedge clk); #3;
    end while (!ok);
    // R10: fields change while busy must not reach the bus
    reqAddr = ~a; reqRegion = rg + 2'd1; reqWdata = ~d; reqWrite = !w;
    reqValid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    fork
      begin
        idle(2);
        // R1 reset state
        chk("R1", "csN", {ramCsN, romCsN, auxCsN}, 3'b111);
        chk("R1", "busWeN", busWeN, 2'b11);
        chk("R1", "busOeN", busOeN, 1'b1);
        chk("R1", "reqReady", reqReady, 1'b1);
        chk("R1", "rspValid", rspValid, 1'b0);
        chk("R1", "busAddr", busAddr, 16'h0);
        chk("R1", "rspRdata", rspRdata, 16'h0);
        rstN = 1;
        idle(2);
        issue(1, 2'd0, 16'h1234, 16'hA5C3, 2'b11, 4'd0);  // R4 RAM write
        idle(4);
        issue(1, 2'd1, 16'h00F0, 16'h5A5A, 2'b01, 4'd3);  // R4 low byte only
        idle(6);
        issue(1, 2'd2, 16'h4321, 16'h0F0F, 2'b00, 4'd1);  // R4 no byte
        idle(5);
        busDataIn = 16'hBEEF;
        issue(0, 2'd2, 16'h7777, 16'h0, 2'b00, 4'd2);     // R7 AUX read
        idle(5);
        busDataIn = 16'hCAFE;
        issue(0, 2'd3, 16'h9999, 16'h0, 2'b00, 4'd0);     // R3 no device
        idle(4);
        busRdy = 0;                                         // R6 ready extension
        busDataIn = 16'h1357;
        issue(0, 2'd0, 16'h2468, 16'h0, 2'b00, 4'd1);
        idle(5);
        busDataIn = 16'h8642;
        busRdy = 1;
        idle(4);
        busRdy = 0;                                         // R6 write extended
        issue(1, 2'd1, 16'hABCD, 16'h3C3C, 2'b10, 4'd0);
        idle(3);
        busRdy = 1;
        idle(4);
        // R8 back to back
        issue(1, 2'd0, 16'h0001, 16'h1111, 2'b11, 4'd0);
        issue(0, 2'd1, 16'h0002, 16'h0, 2'b00, 4'd0);
        issue(1, 2'd2, 16'h0003, 16'h3333, 2'b01, 4'd2);
        idle(6);
        // R5 every wait-state count
        for (int ws = 0; ws < 16; ws++) begin
          busDataIn = 16'(ws * 16'h0101 + 16'h0042);
          issue(ws[0], 2'(ws % 4), 16'(ws * 16'h0111), 16'(ws * 16'h1001), 2'(ws % 4), 4'(ws));
        end
        idle(24);
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule